// File: doc/BRIEF.md
# UART Buffer Watermark Interrupt Controller

This block tracks how full the transmit and receive buffers of a UART are and turns that occupancy into status flags and two interrupt requests. Each buffer holds eight entries. The block counts pushes and pops that the host and the serial engines report as strobes. It does not store the data itself. It only keeps the count that the real storage would have.

Software programs two 3-bit watermark selects over a simple write strobe. On the transmit side, a larger code asks for an interrupt earlier, while more of the buffer is still occupied. On the receive side, a larger code asks for an interrupt later, once more words are waiting. The receive request is held off while an enabled parity or framing error is pending, so that the error is serviced first. A host write into a full transmit buffer is dropped and leaves a sticky error flag, which only a software clear removes.

Top module: `uart_wm_irq_ctrl`

## Requirements
- R1: After reset both select fields are 0, both empty flags are 1, both full flags are 0, the write error flag is 0, the TX interrupt is 1 and the RX interrupt is 0.
- R2: A push that is accepted raises a buffer's count by one. A pop that is accepted lowers it by one. An accepted push together with an accepted pop leaves it unchanged. The empty flag is 1 exactly when the count is 0, and the full flag is 1 exactly when the count is 8.
- R3: The TX interrupt is 1 exactly when the number of free transmit slots (8 minus the count) is at least 8 minus the TX select code. Code 0 therefore needs an empty buffer, and code 7 needs one free slot.
- R4: When no masking error is pending, the RX interrupt is 1 exactly when the receive count is at least the RX select code plus 1. Code 0 therefore needs one word, and code 7 needs a full buffer.
- R5: The RX interrupt is forced to 0 while the parity error input and its enable are both 1, and also while the framing error input and its enable are both 1. An error whose enable is 0 does not mask it.
- R6: A TX push while the TX buffer is full is not accepted, and the count stays at 8 unless a pop occurs in the same cycle. The write error flag is 1 from the next cycle.
- R7: The write error flag stays 1 until a clear strobe arrives. If a new overflow occurs in the same cycle as the clear, the flag stays 1.
- R8: A pop from an empty buffer is ignored and the count stays 0. An RX push into a full receive buffer is dropped and the count stays 8.
- R9: The select fields load only in a cycle with the config write strobe at 1. At other times, changes on the select inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads both select fields |
| cfg_tx_sel_i | input | 3 | TX watermark select code |
| cfg_rx_sel_i | input | 3 | RX watermark select code |
| werr_clr_i | input | 1 | Software clear of the write error flag |
| tx_push_i | input | 1 | Host writes a byte to the TX buffer |
| tx_pop_i | input | 1 | Transmitter takes a byte from the TX buffer |
| rx_push_i | input | 1 | Receiver stores a word in the RX buffer |
| rx_pop_i | input | 1 | Host reads a word from the RX buffer |
| par_err_i | input | 1 | Parity error pending |
| par_ie_i | input | 1 | Parity error interrupt enable |
| frm_err_i | input | 1 | Framing error pending |
| frm_ie_i | input | 1 | Framing error interrupt enable |
| tx_empty_o | output | 1 | TX buffer empty |
| tx_full_o | output | 1 | TX buffer full |
| rx_empty_o | output | 1 | RX buffer empty |
| rx_full_o | output | 1 | RX buffer full |
| tx_werr_o | output | 1 | Sticky TX write error |
| tx_irq_o | output | 1 | TX watermark interrupt request |
| rx_irq_o | output | 1 | RX watermark interrupt request |

## Verification
The bench fills both buffers to the limit and pushes beyond it. A design that counted past eight or wrapped to zero would then show wrong full, empty and interrupt levels. It runs every select code on both sides and checks the edges of each threshold, which catches an off-by-one or a reversed direction in the TX or RX mapping. It sends an overflow and a clear in the same cycle, and it raises errors with their enables both on and off. This catches a clear that wins over a new overflow, and a mask that ignores its enable. It also changes the select inputs while the write strobe is low, which exposes a field that loads without the strobe.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
  typedef enum logic {
    BUF_TX = 1'b0,
    BUF_RX = 1'b1
  } buf_id_e;
  localparam int unsigned NUM_BUF = 2;
endpackage

// File: rtl/uart_wm_occ.sv
module uart_wm_occ #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             push_drop_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign full_o      = (cnt_q == CNT_MAX);
  assign empty_o     = (cnt_q == '0);
  assign push_ok     = push_i && !full_o;
  assign pop_ok      = pop_i && !empty_o;
  assign push_drop_o = push_i && full_o;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_ok && !pop_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  a_r2_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o) |=> $stable(cnt_q));
  a_r6_full_push_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == CNT_MAX));
  a_r8_empty_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/uart_wm_cfg.sv
module uart_wm_cfg #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] tx_sel_i,
  input  logic [SEL_W-1:0] rx_sel_i,
  input  logic             werr_set_i,
  input  logic             werr_clr_i,
  output logic [SEL_W-1:0] tx_sel_o,
  output logic [SEL_W-1:0] rx_sel_o,
  output logic             werr_o
);
  logic [SEL_W-1:0] tx_sel_q, rx_sel_q;
  logic werr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sel_q <= '0;
      rx_sel_q <= '0;
    end else if (cfg_we_i) begin
      tx_sel_q <= tx_sel_i;
      rx_sel_q <= rx_sel_i;
    end
  end

  // a new overflow wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         werr_q <= 1'b0;
    else if (werr_set_i) werr_q <= 1'b1;
    else if (werr_clr_i) werr_q <= 1'b0;
  end

  assign tx_sel_o = tx_sel_q;
  assign rx_sel_o = rx_sel_q;
  assign werr_o   = werr_q;

  a_r9_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(tx_sel_q) && $stable(rx_sel_q)));
  a_r6_werr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    werr_set_i |=> werr_q);
  a_r7_werr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (werr_q && !werr_clr_i) |=> werr_q);
endmodule

// File: rtl/uart_wm_irq_ctrl.sv
module uart_wm_irq_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_tx_sel_i,
  input  logic [SEL_W-1:0] cfg_rx_sel_i,
  input  logic             werr_clr_i,
  input  logic             tx_push_i,
  input  logic             tx_pop_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             par_err_i,
  input  logic             par_ie_i,
  input  logic             frm_err_i,
  input  logic             frm_ie_i,
  output logic             tx_empty_o,
  output logic             tx_full_o,
  output logic             rx_empty_o,
  output logic             rx_full_o,
  output logic             tx_werr_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o
);
  import uart_wm_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [NUM_BUF-1:0] push, pop, empty, full, drop;
  logic [CNT_W-1:0]   cnt [NUM_BUF];
  logic [SEL_W-1:0]   tx_sel, rx_sel;
  logic               rx_mask;

  assign push[BUF_TX] = tx_push_i;
  assign pop[BUF_TX]  = tx_pop_i;
  assign push[BUF_RX] = rx_push_i;
  assign pop[BUF_RX]  = rx_pop_i;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    uart_wm_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push[b]),
      .pop_i       (pop[b]),
      .cnt_o       (cnt[b]),
      .empty_o     (empty[b]),
      .full_o      (full[b]),
      .push_drop_o (drop[b])
    );
  end

  uart_wm_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .tx_sel_i   (cfg_tx_sel_i),
    .rx_sel_i   (cfg_rx_sel_i),
    .werr_set_i (drop[BUF_TX]),
    .werr_clr_i (werr_clr_i),
    .tx_sel_o   (tx_sel),
    .rx_sel_o   (rx_sel),
    .werr_o     (tx_werr_o)
  );

  // free slots >= DEPTH-sel  <=>  count <= sel
  // words >= sel+1           <=>  count >  sel
  assign rx_mask  = (par_err_i && par_ie_i) || (frm_err_i && frm_ie_i);
  assign tx_irq_o = (cnt[BUF_TX] <= CNT_W'(tx_sel));
  assign rx_irq_o = (cnt[BUF_RX] > CNT_W'(rx_sel)) && !rx_mask;

  assign tx_empty_o = empty[BUF_TX];
  assign tx_full_o  = full[BUF_TX];
  assign rx_empty_o = empty[BUF_RX];
  assign rx_full_o  = full[BUF_RX];

  a_r5_rx_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((par_err_i && par_ie_i) || (frm_err_i && frm_ie_i)) |-> !rx_irq_o);
  a_r4_rx_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rx_irq_o);
  a_r3_tx_full_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> !tx_irq_o);
  a_r3_tx_empty_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_irq_o);
endmodule

// File: tb/uart_wm_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_wm_irq_ctrl_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 0, werr_clr_i = 0;
  logic [2:0] cfg_tx_sel_i = 0, cfg_rx_sel_i = 0;
  logic tx_push_i = 0, tx_pop_i = 0, rx_push_i = 0, rx_pop_i = 0;
  logic par_err_i = 0, par_ie_i = 0, frm_err_i = 0, frm_ie_i = 0;
  logic tx_empty_o, tx_full_o, rx_empty_o, rx_full_o, tx_werr_o, tx_irq_o, rx_irq_o;

  int tests = 0, fails = 0;
  int m_tx = 0, m_rx = 0, m_txsel = 0, m_rxsel = 0;
  bit m_werr = 0, done = 0;

  always #5 clk_i = ~clk_i;

  uart_wm_irq_ctrl uut (.*);

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_tx_irq(int cnt, int sel);
    return (8 - cnt) >= (8 - sel);
  endfunction

  function automatic bit exp_rx_irq(int cnt, int sel, bit pe, bit pie, bit fe, bit fie);
    if ((pe && pie) || (fe && fie)) return 0;
    return cnt >= sel + 1;
  endfunction

  task automatic model_edge();
    bit txp_ok, txo_ok, rxp_ok, rxo_ok;
    txp_ok = tx_push_i && m_tx < 8;
    txo_ok = tx_pop_i && m_tx > 0;
    rxp_ok = rx_push_i && m_rx < 8;
    rxo_ok = rx_pop_i && m_rx > 0;
    if (tx_push_i && m_tx == 8) m_werr = 1;
    else if (werr_clr_i) m_werr = 0;
    m_tx = m_tx + int'(txp_ok) - int'(txo_ok);
    m_rx = m_rx + int'(rxp_ok) - int'(rxo_ok);
    if (cfg_we_i) begin
      m_txsel = cfg_tx_sel_i;
      m_rxsel = cfg_rx_sel_i;
    end
  endtask

  task automatic check_all();
    bit masked;
    masked = (par_err_i && par_ie_i) || (frm_err_i && frm_ie_i);
    chk("R2 tx_empty", tx_empty_o, m_tx == 0);
    chk("R2 tx_full", tx_full_o, m_tx == 8);
    chk("R2 rx_empty", rx_empty_o, m_rx == 0);
    chk("R2 rx_full", rx_full_o, m_rx == 8);
    chk("R3 tx_irq", tx_irq_o, exp_tx_irq(m_tx, m_txsel));
    chk(masked ? "R5 rx_irq" : "R4 rx_irq", rx_irq_o,
        exp_rx_irq(m_rx, m_rxsel, par_err_i, par_ie_i, frm_err_i, frm_ie_i));
    chk("R6/R7 tx_werr", tx_werr_o, m_werr);
  endtask

  // inputs are set at negedge; the model follows the posedge; outputs are checked at the next negedge
  task automatic cycle();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all();
  endtask

  task automatic idle_inputs();
    cfg_we_i = 0; werr_clr_i = 0;
    tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 tx_empty", tx_empty_o, 1);
    chk("R1 rx_empty", rx_empty_o, 1);
    chk("R1 tx_full", tx_full_o, 0);
    chk("R1 rx_full", rx_full_o, 0);
    chk("R1 tx_werr", tx_werr_o, 0);
    chk("R1 tx_irq", tx_irq_o, 1);
    chk("R1 rx_irq", rx_irq_o, 0);
    rst_ni = 1;
    cycle();

    // R9: select inputs change without the write strobe
    cfg_rx_sel_i = 7; cfg_tx_sel_i = 7; rx_push_i = 1;
    cycle();
    idle_inputs();
    cycle();
    chk("R9 rx_irq keeps sel 0", rx_irq_o, 1);

    // R8: pop the only word, then pop the empty buffer
    rx_pop_i = 1; cycle();
    cycle();
    idle_inputs();
    chk("R8 rx_empty after empty pop", rx_empty_o, 1);
    tx_pop_i = 1; cycle(); idle_inputs();
    chk("R8 tx_empty after empty pop", tx_empty_o, 1);

    // R6: fill TX to 8, then overflow
    cfg_we_i = 1; cfg_tx_sel_i = 7; cfg_rx_sel_i = 7; cycle(); idle_inputs();
    tx_push_i = 1;
    repeat (8) cycle();
    chk("R6 tx_full at 8", tx_full_o, 1);
    cycle();
    idle_inputs();
    chk("R6 werr set", tx_werr_o, 1);
    chk("R6 still full", tx_full_o, 1);
    // R7: clear together with a new overflow keeps the flag
    tx_push_i = 1; werr_clr_i = 1; cycle(); idle_inputs();
    chk("R7 set beats clear", tx_werr_o, 1);
    cycle();
    chk("R7 sticky", tx_werr_o, 1);
    werr_clr_i = 1; cycle(); idle_inputs();
    chk("R7 cleared", tx_werr_o, 0);

    // R8: fill RX, then push more
    rx_push_i = 1; repeat (10) cycle(); idle_inputs();
    chk("R8 rx full stays", rx_full_o, 1);
    chk("R4 rx_irq sel7 full", rx_irq_o, 1);
    // R5: masks
    par_err_i = 1; cycle(); chk("R5 par no enable", rx_irq_o, 1);
    par_ie_i = 1; cycle(); chk("R5 par masked", rx_irq_o, 0);
    par_err_i = 0; frm_err_i = 1; frm_ie_i = 1; cycle(); chk("R5 frm masked", rx_irq_o, 0);
    frm_err_i = 0; par_ie_i = 0; frm_ie_i = 0; cycle();

    // R3/R4: sweep all codes at all counts
    for (int s = 0; s < 8; s++) begin
      cfg_we_i = 1; cfg_tx_sel_i = 3'(s); cfg_rx_sel_i = 3'(7 - s); cycle(); idle_inputs();
      tx_pop_i = 1; rx_pop_i = 1; repeat (9) cycle(); idle_inputs();
      tx_push_i = 1; rx_push_i = 1; repeat (9) cycle(); idle_inputs();
    end

    // constrained random phases with varying fill bias
    for (int ph = 0; ph < 8; ph++) begin
      int pp;
      pp = (ph % 2 == 0) ? 70 : 30;
      for (int n = 0; n < 600; n++) begin
        tx_push_i  = ($urandom_range(0, 99) < pp);
        tx_pop_i   = ($urandom_range(0, 99) < 100 - pp);
        rx_push_i  = ($urandom_range(0, 99) < pp);
        rx_pop_i   = ($urandom_range(0, 99) < 100 - pp);
        cfg_we_i   = ($urandom_range(0, 99) < 5);
        cfg_tx_sel_i = 3'($urandom_range(0, 7));
        cfg_rx_sel_i = 3'($urandom_range(0, 7));
        werr_clr_i = ($urandom_range(0, 99) < 10);
        par_err_i  = ($urandom_range(0, 99) < 15);
        par_ie_i   = $urandom_range(0, 1) == 1;
        frm_err_i  = ($urandom_range(0, 99) < 15);
        frm_ie_i   = $urandom_range(0, 1) == 1;
        cycle();
      end
    end
    idle_inputs();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule